// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Slave

This block is the slave end of an 8-bit bus that carries the address and the data on the same pins. Every bus cycle starts with an address phase. The bus value is captured as the address when the address strobe falls. A data-transfer phase follows, in which the same pins carry read data out of the block or write data into it. Behind the bus sits a byte-wide register file of 64 entries. The block has no other access to that file, so the bus alone writes it and reads it back.

Two strobe conventions share one address latch, and a mode input picks between them.
- **Split-strobe mode** (mode input low): the data-strobe pin is an active-low read strobe and the direction pin is an active-low write strobe.
- **Direction-strobe mode** (mode input high): the data strobe is active high and the direction pin chooses the transfer, high for read and low for write.

The mode is taken once, on the first clock after reset is released, and it is then held until the next reset. A power-fail input blocks every write. The bidirectional pins are split into an input bus, an output bus and an output enable.

All strobes, the chip select, the power-fail input and the input bus go through two-flop synchronizers into the system clock. An enumerated state machine follows the bus cycle. Its states are:
- **ST_IDLE**: no valid address is held.
- **ST_ADDR**: an address has been captured and the block waits for a data strobe.
- **ST_READ**: the block drives the bus.
- **ST_WRITE**: a write strobe is active.

Its transitions are:
- **ST_IDLE to ST_ADDR**: the address strobe falls.
- **ST_ADDR to ST_ADDR**: a new address strobe falls, and the address is captured again.
- **ST_ADDR to ST_READ**: chip select is low and the read condition holds.
- **ST_ADDR to ST_WRITE**: chip select is low and the write condition holds.
- **ST_READ to ST_IDLE**: the read condition ends or chip select rises.
- **ST_WRITE to ST_IDLE**: the write strobe ends, which commits the write unless power-fail is asserted. The same transition is taken when chip select rises, and the write is then abandoned without a commit.

Top module: `muxbus_slave`

## Requirements
- R1: After reset, ad_oe is 0 and ad_out is 0. Every register-file entry reads as 0x00, and the mode is split-strobe.
- R2: The value on ad_in is captured as the address when addr_stb falls. The address is captured only in an address phase, never during a data transfer.
- R3: In split-strobe mode, a captured address with cs_n low and data_stb low (read strobe) makes ad_oe go to 1 and ad_out carry the addressed byte. Both return to 0 once data_stb goes high.
- R4: In split-strobe mode, a write is committed when dir_stb (write strobe, active low) rises while cs_n is low. The byte written is the ad_in value present at that edge.
- R5: In direction-strobe mode, dir_stb high (read) with data_stb high and cs_n low drives the addressed byte on ad_out with ad_oe at 1, for as long as data_stb stays high.
- R6: In direction-strobe mode, dir_stb low (write) with cs_n low commits the ad_in byte on the falling edge of data_stb.
- R7: While cs_n is high, the strobes cause no drive and no write.
- R8: mode_sel is sampled on the first clock after reset release (0 selects split-strobe, 1 selects direction-strobe). Later changes of mode_sel have no effect until the next reset.
- R9: While pwr_fail is 1, no write changes the register file.
- R10: Only addresses 0x00 to 0x3F select a register. A read of a higher address returns 0x00, and a write to a higher address changes no register (no aliasing onto the low 64).
- R11: Every data transfer needs a new address phase. A strobe that arrives after a completed transfer, with no new addr_stb fall, causes no drive and no write.
- R12: ad_oe is 0 throughout every address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | Strobe convention: 0 split-strobe, 1 direction-strobe |
| cs_n | input | 1 | Active-low chip select |
| addr_stb | input | 1 | Address strobe; the address is captured on its falling edge |
| data_stb | input | 1 | Read strobe (active low) in split-strobe mode; data strobe (active high) in direction-strobe mode |
| dir_stb | input | 1 | Write strobe (active low) in split-strobe mode; read/write direction (1 = read) in direction-strobe mode |
| pwr_fail | input | 1 | Power-fail indication; 1 blocks all writes |
| ad_in | input | 8 | Multiplexed bus, input side |
| ad_out | output | 8 | Multiplexed bus, output side (0 when not driving) |
| ad_oe | output | 1 | Output enable for the multiplexed bus |

## Verification
The hardest situations to reach from the ports are the strobes that must be ignored. One is a read strobe that repeats after a finished transfer with no new address phase. Another is a mode pin that changes after the mode has been latched. The third arises in direction-strobe mode, where the idle pin levels already look like a split-strobe read once chip select drops. The stimulus builds each of these on purpose and watches ad_oe for an unexpected rise. A scoreboard monitor treats any drive that has no queued expectation as a failure.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADDR  = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } bus_st_t;

    typedef enum logic {
        MODE_SPLIT = 1'b0,
        MODE_DIR   = 1'b1
    } bus_mode_t;

endpackage

// File: rtl/mb_sync.sv
module mb_sync #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta;
        logic stab;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta <= RST_VAL[i];
                stab <= RST_VAL[i];
            end else begin
                meta <= d[i];
                stab <= meta;
            end
        end
        assign q[i] = stab;
    end
endmodule

// File: rtl/mb_regfile.sv
module mb_regfile #(
    parameter int BUS_W = 8,
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata
);
    localparam int AW = $clog2(DEPTH);

    logic [BUS_W-1:0] mem [DEPTH];
    logic             in_range;
    logic [AW-1:0]    idx;

    assign in_range = (addr >> AW) == '0;
    assign idx      = addr[AW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en && in_range) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = in_range ? mem[idx] : '0;
endmodule

// File: rtl/mb_fsm.sv
module mb_fsm
    import muxbus_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bus_mode_t        mode,
    input  logic             s_astb,
    input  logic             s_dstb,
    input  logic             s_rw,
    input  logic             s_cs_n,
    input  logic             s_pf,
    input  logic [BUS_W-1:0] s_ad,
    output logic [BUS_W-1:0] addr_q,
    output logic             rd_act,
    output logic             wr_en
);
    bus_st_t state, state_nx;
    logic    p_astb;
    logic    astb_fall;
    logic    rd_cond, wr_start, wr_end;
    logic    addr_phase;

    assign astb_fall  = p_astb & ~s_astb;
    assign addr_phase = (state == ST_IDLE) || (state == ST_ADDR);

    always_comb begin
        if (mode == MODE_SPLIT) begin
            rd_cond  = !s_dstb;
            wr_start = !s_rw;
            wr_end   = s_rw;
        end else begin
            rd_cond  = s_dstb && s_rw;
            wr_start = s_dstb && !s_rw;
            wr_end   = !s_dstb;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            p_astb <= 1'b0;
        end else begin
            state  <= state_nx;
            p_astb <= s_astb;
        end
    end

    // shared address latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       addr_q <= '0;
        else if (addr_phase && astb_fall) addr_q <= s_ad;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (astb_fall) state_nx = ST_ADDR;
            ST_ADDR: begin
                if (astb_fall)                  state_nx = ST_ADDR;
                else if (!s_cs_n && rd_cond)    state_nx = ST_READ;
                else if (!s_cs_n && wr_start)   state_nx = ST_WRITE;
            end
            ST_READ:  if (s_cs_n || !rd_cond) state_nx = ST_IDLE;
            ST_WRITE: if (s_cs_n || wr_end)   state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rd_act = 1'b0;
        wr_en  = 1'b0;
        unique case (state)
            ST_IDLE, ST_ADDR: ;
            ST_READ:  rd_act = 1'b1;
            ST_WRITE: wr_en  = !s_cs_n && wr_end && !s_pf;
            default: ;
        endcase
    end

    // R7
    oe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_act |-> $past(!s_cs_n));

    // R2
    addr_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (astb_fall && addr_phase) |=> (addr_q == $past(s_ad)));
endmodule

// File: rtl/muxbus_slave.sv
module muxbus_slave
    import muxbus_pkg::*;
#(
    parameter int BUS_W = 8,
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_sel,
    input  logic             cs_n,
    input  logic             addr_stb,
    input  logic             data_stb,
    input  logic             dir_stb,
    input  logic             pwr_fail,
    input  logic [BUS_W-1:0] ad_in,
    output logic [BUS_W-1:0] ad_out,
    output logic             ad_oe
);
    localparam int            CTL_W   = 5;
    localparam logic [BUS_W-1:0] DEPTH_B = BUS_W'(DEPTH);

    bus_mode_t        mode_q;
    logic             mode_ld;
    logic [CTL_W-1:0] ctl_raw, ctl_s;
    logic [BUS_W-1:0] ad_s;
    logic [BUS_W-1:0] addr_q, rdata;
    logic             rd_act, wr_en;
    logic             s_astb, s_dstb, s_rw, s_cs_n, s_pf;

    // mode is taken once after reset release
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= MODE_SPLIT;
            mode_ld <= 1'b0;
        end else if (!mode_ld) begin
            mode_q  <= bus_mode_t'(mode_sel);
            mode_ld <= 1'b1;
        end
    end

    assign ctl_raw = {pwr_fail, cs_n, dir_stb, data_stb, addr_stb};

    mb_sync #(.W(CTL_W), .RST_VAL(5'b11110)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s));

    mb_sync #(.W(BUS_W), .RST_VAL('0)) u_ad_sync (
        .clk(clk), .rst_n(rst_n), .d(ad_in), .q(ad_s));

    assign {s_pf, s_cs_n, s_rw, s_dstb, s_astb} = ctl_s;

    mb_fsm #(.BUS_W(BUS_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .mode(mode_q),
        .s_astb(s_astb), .s_dstb(s_dstb), .s_rw(s_rw),
        .s_cs_n(s_cs_n), .s_pf(s_pf), .s_ad(ad_s),
        .addr_q(addr_q), .rd_act(rd_act), .wr_en(wr_en));

    mb_regfile #(.BUS_W(BUS_W), .DEPTH(DEPTH)) u_rf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .addr(addr_q), .wdata(ad_s), .rdata(rdata));

    assign ad_oe  = rd_act;
    assign ad_out = rd_act ? rdata : '0;

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_ld |=> $stable(mode_q));

    // R9
    pf_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !s_pf);

    // R10
    oor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && (addr_q >= DEPTH_B)) |-> (ad_out == '0));
endmodule

// File: tb/sim_muxbus_slave.sv
module sim_muxbus_slave;
    localparam int W = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_sel = 1'b0;
    logic       cs_n = 1'b1, addr_stb = 1'b0, data_stb = 1'b1, dir_stb = 1'b1;
    logic       pwr_fail = 1'b0;
    logic [7:0] ad_in = '0;
    logic [7:0] ad_out;
    logic       ad_oe;

    int checks = 0, fails = 0, m_checks = 0, m_fails = 0;
    string      tagq[$];
    logic [7:0] valq[$];
    logic [7:0] model [64];
    logic       cur_mode = 1'b0;
    logic       prev_oe = 1'b0;

    always #10 clk = ~clk;

    muxbus_slave u0 (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n),
        .addr_stb(addr_stb), .data_stb(data_stb), .dir_stb(dir_stb),
        .pwr_fail(pwr_fail), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe));

    // monitor: compare each bus drive against the scoreboard
    always @(negedge clk) begin
        if (rst_n && ad_oe && !prev_oe) begin
            m_checks++;
            if (tagq.size() == 0) begin
                m_fails++;
                $display("FAIL R12 unexpected bus drive: act=%02h exp=no drive", ad_out);
            end else begin
                string      t;
                logic [7:0] v;
                t = tagq.pop_front();
                v = valq.pop_front();
                if (ad_out !== v) begin
                    m_fails++;
                    $display("FAIL %s read data: act=%02h exp=%02h", t, ad_out, v);
                end
            end
        end
        prev_oe <= ad_oe;
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%02h exp=%02h", tag, act, exp);
        end
    endtask

    task automatic wt(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle_lines();
        cs_n = 1'b1; addr_stb = 1'b0; dir_stb = 1'b1;
        data_stb = cur_mode ? 1'b0 : 1'b1;
    endtask

    task automatic do_reset(logic m);
        @(negedge clk);
        rst_n = 1'b0; mode_sel = m; cur_mode = m; pwr_fail = 1'b0;
        idle_lines();
        for (int i = 0; i < 64; i++) model[i] = 8'h00;
        wt(3);
        rst_n = 1'b1;
        wt(W);
    endtask

    task automatic expect_of(logic [7:0] a, string tag);
        tagq.push_back(tag);
        valq.push_back(a < 8'd64 ? model[a[5:0]] : 8'h00);
    endtask

    task automatic addr_phase(logic [7:0] a);
        logic seen;
        seen = 1'b0;
        ad_in = a; addr_stb = 1'b1;
        for (int i = 0; i < W; i++) begin @(negedge clk); seen |= ad_oe; end
        addr_stb = 1'b0;
        for (int i = 0; i < W; i++) begin @(negedge clk); seen |= ad_oe; end
        chk("R12 oe during address phase", {7'd0, seen}, 8'h00);
    endtask

    task automatic split_read(logic [7:0] a, string tag);
        addr_phase(a);
        expect_of(a, tag);
        cs_n = 1'b0; data_stb = 1'b0; wt(W);
        data_stb = 1'b1; cs_n = 1'b1; wt(W);
        chk("R3 release after read", {7'd0, ad_oe}, 8'h00);
    endtask

    task automatic split_write(logic [7:0] a, logic [7:0] d);
        addr_phase(a);
        ad_in = d; cs_n = 1'b0; dir_stb = 1'b0; wt(W);
        dir_stb = 1'b1; wt(W);
        cs_n = 1'b1; wt(2);
        if (!pwr_fail && a < 8'd64) model[a[5:0]] = d;
    endtask

    task automatic dir_read(logic [7:0] a, string tag);
        addr_phase(a);
        expect_of(a, tag);
        cs_n = 1'b0; dir_stb = 1'b1; data_stb = 1'b1; wt(W);
        data_stb = 1'b0; wt(W);
        chk("R5 release after read", {7'd0, ad_oe}, 8'h00);
        cs_n = 1'b1; wt(2);
    endtask

    task automatic dir_write(logic [7:0] a, logic [7:0] d);
        addr_phase(a);
        ad_in = d; cs_n = 1'b0; dir_stb = 1'b0; wt(W);
        data_stb = 1'b1; wt(W);
        data_stb = 1'b0; wt(W);
        dir_stb = 1'b1; cs_n = 1'b1; wt(2);
        if (!pwr_fail && a < 8'd64) model[a[5:0]] = d;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog expired: act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks + m_checks + 1, fails + m_fails + 1);
        $finish;
    end

    initial begin : stim
        logic seen;
        do_reset(1'b0);
        // R1 reset state
        chk("R1 oe after reset", {7'd0, ad_oe}, 8'h00);
        chk("R1 out after reset", ad_out, 8'h00);
        split_read(8'h05, "R1 reset content");

        // R4 / R3 split-strobe write and read, incl. top address
        split_write(8'h03, 8'h5A);
        split_read(8'h03, "R3 read after R4 write");
        split_write(8'h3F, 8'hC3);
        split_read(8'h3F, "R3 top register");
        split_read(8'h03, "R2 address recaptured");

        // R11 strobe with no new address phase
        cs_n = 1'b0; data_stb = 1'b0; wt(W);
        chk("R11 no drive without address", {7'd0, ad_oe}, 8'h00);
        data_stb = 1'b1; cs_n = 1'b1; wt(W);

        // R7 chip select high: no drive, no write
        addr_phase(8'h03);
        seen = 1'b0;
        data_stb = 1'b0;
        for (int i = 0; i < W; i++) begin @(negedge clk); seen |= ad_oe; end
        data_stb = 1'b1; wt(2);
        chk("R7 no drive with cs high", {7'd0, seen}, 8'h00);
        addr_phase(8'h03);
        ad_in = 8'hFF; dir_stb = 1'b0; wt(W); dir_stb = 1'b1; wt(W);
        split_read(8'h03, "R7 write ignored with cs high");

        // R9 power fail blocks writes
        pwr_fail = 1'b1; wt(W);
        split_write(8'h03, 8'h11);
        pwr_fail = 1'b0; wt(W);
        split_read(8'h03, "R9 write blocked");

        // R10 out-of-range addresses
        split_write(8'h43, 8'hAA);
        split_read(8'h03, "R10 no aliasing");
        split_read(8'h43, "R10 high address reads zero");

        // R8 mode pin change after reset ignored
        mode_sel = 1'b1; wt(W);
        split_read(8'h3F, "R8 mode held split");

        // direction-strobe mode
        do_reset(1'b1);
        mode_sel = 1'b0; wt(W);
        chk("R1 oe after second reset", {7'd0, ad_oe}, 8'h00);
        dir_write(8'h0A, 8'h3C);
        dir_read(8'h0A, "R5 read after R6 write");
        dir_read(8'h3F, "R1 register cleared by reset");
        addr_phase(8'h0A);
        seen = 1'b0;
        cs_n = 1'b0;
        for (int i = 0; i < W; i++) begin @(negedge clk); seen |= ad_oe; end
        cs_n = 1'b1; wt(2);
        chk("R8 split read pattern ignored in direction mode", {7'd0, seen}, 8'h00);
        pwr_fail = 1'b1; wt(W);
        dir_write(8'h0A, 8'h77);
        pwr_fail = 1'b0; wt(W);
        dir_read(8'h0A, "R9 direction write blocked");
        dir_write(8'h55, 8'h99);
        dir_read(8'h15, "R10 direction no aliasing");
        dir_read(8'h55, "R6 high write ignored");

        wt(4);
        chk("R3 all expected reads seen", 8'(tagq.size()), 8'h00);
        $display("TB_RESULT checks=%0d failures=%0d", checks + m_checks, fails + m_fails);
        $finish;
    end
endmodule